// File: doc/BRIEF.md
# Sorting-Network Seven-Input Bit Counter

This block reports how many of seven single-bit inputs are high, as a 3-bit binary number from 0 to 7. It does not use a tree of full adders. The input vector is split into two groups of unequal size: four bits and three bits. Each group passes through a small network of 1-bit compare-exchange cells. The network moves every one to the top of the group, so the group's output is a thermometer code.

Each thermometer code is then recoded into a one-hot word. The set bit sits at the index equal to the number of ones in that group. The two one-hot words are combined into a single one-hot sum, which is then encoded as a binary count. The block is meant to sit inside a reduction tree that sums many operands, such as a multiplier's partial-product compression stage.

An optional output register, selected by a parameter, places the count behind a flop for timing work. Without it, the count is purely combinational.

Top module: `sortnet_counter7`

## Requirements
- R1: `count_o` equals the number of ones in `bits_i`, for all 128 input values.
- R2: `bits_i[3:0]` form the four-bit group and `bits_i[6:4]` form the three-bit group. Each group is sorted on its own, and the sorted word of each group holds as many ones as its inputs.
- R3: Every compare-exchange cell drives its upper output with the OR of its two inputs and its lower output with their AND. This is one level of two-input gates per cell.
- R4: Each sorted word is a thermometer code: index 0 is the top, and no zero sits above a one.
- R5: Each group's one-hot word has exactly one bit set, at the index equal to that group's count of ones (0 to 4 for the four-bit group, 0 to 3 for the three-bit group).
- R6: With `REG_OUT` = 0, `count_o` follows `bits_i` within the same cycle, with no clock involved.
- R7: With `REG_OUT` = 1, `count_o` takes the count of the `bits_i` value present at a rising edge of `clk_i`, and holds it until the next edge.
- R8: With `REG_OUT` = 1, a low `rst_ni` clears `count_o` to 0 asynchronously, whatever value `bits_i` has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| bits_i | input | 7 | Bits to be counted; [3:0] is the four-bit group, [6:4] is the three-bit group |
| count_o | output | 3 | Binary number of ones in `bits_i` |

## Verification
The bench builds two copies of the block side by side. One uses `REG_OUT` = 1, which brings in the register timing and the reset-clear behaviour. The other uses `REG_OUT` = 0, which exposes the combinational path within the same cycle. Both copies see every one of the 128 input patterns. Further directed patterns fill one group while leaving the other empty, and walk a single one through each position, so that every one-hot index of both groups and every cell's OR and AND paths are reached.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;
  localparam int unsigned N_IN  = 7;
  localparam int unsigned GRP_A = 4;              // four-bit group, bits_i[3:0]
  localparam int unsigned GRP_B = N_IN - GRP_A;   // three-bit group, bits_i[6:4]
  localparam int unsigned CNT_W = $clog2(N_IN + 1);
endpackage

// File: rtl/cx_cell.sv
module cx_cell (
  input  logic a_i,
  input  logic b_i,
  output logic hi_o,
  output logic lo_o
);
  assign hi_o = a_i | b_i;
  assign lo_o = a_i & b_i;
endmodule

// File: rtl/sort4_net.sv
// Three cell levels: (0,1)(2,3) ; (0,2)(1,3) ; (1,2)
module sort4_net (
  input  logic [3:0] d_i,
  output logic [3:0] q_o
);
  logic [3:0] l1, l2;

  cx_cell u_c0 (.a_i(d_i[0]), .b_i(d_i[1]), .hi_o(l1[0]), .lo_o(l1[1]));
  cx_cell u_c1 (.a_i(d_i[2]), .b_i(d_i[3]), .hi_o(l1[2]), .lo_o(l1[3]));
  cx_cell u_c2 (.a_i(l1[0]),  .b_i(l1[2]),  .hi_o(l2[0]), .lo_o(l2[2]));
  cx_cell u_c3 (.a_i(l1[1]),  .b_i(l1[3]),  .hi_o(l2[1]), .lo_o(l2[3]));
  cx_cell u_c4 (.a_i(l2[1]),  .b_i(l2[2]),  .hi_o(q_o[1]), .lo_o(q_o[2]));

  assign q_o[0] = l2[0];
  assign q_o[3] = l2[3];
endmodule

// File: rtl/sort3_net.sv
// Three cell levels: (0,1) ; (1,2) ; (0,1)
module sort3_net (
  input  logic [2:0] d_i,
  output logic [2:0] q_o
);
  logic [2:0] l1, l2;

  cx_cell u_c0 (.a_i(d_i[0]), .b_i(d_i[1]), .hi_o(l1[0]), .lo_o(l1[1]));
  assign l1[2] = d_i[2];
  cx_cell u_c1 (.a_i(l1[1]),  .b_i(l1[2]),  .hi_o(l2[1]), .lo_o(l2[2]));
  assign l2[0] = l1[0];
  cx_cell u_c2 (.a_i(l2[0]),  .b_i(l2[1]),  .hi_o(q_o[0]), .lo_o(q_o[1]));
  assign q_o[2] = l2[2];
endmodule

// File: rtl/therm_onehot.sv
module therm_onehot #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] t_i,
  output logic [N:0]   h_o
);
  assign h_o[0] = ~t_i[0];
  assign h_o[N] = t_i[N-1];
  for (genvar k = 1; k < N; k++) begin : g_edge
    assign h_o[k] = t_i[k-1] & ~t_i[k];
  end
endmodule

// File: rtl/onehot_sum.sv
module onehot_sum #(
  parameter int unsigned NA = 4,
  parameter int unsigned NB = 3,
  parameter int unsigned W  = 3
) (
  input  logic [NA:0]  ha_i,
  input  logic [NB:0]  hb_i,
  output logic [W-1:0] bin_o
);
  localparam int unsigned NS = NA + NB + 1;
  logic [NS-1:0] sum_hot;

  always_comb begin
    sum_hot = '0;
    for (int i = 0; i <= NA; i++) begin
      for (int j = 0; j <= NB; j++) begin
        sum_hot[i+j] = sum_hot[i+j] | (ha_i[i] & hb_i[j]);
      end
    end
  end

  always_comb begin
    bin_o = '0;
    for (int v = 0; v < NS; v++) begin
      bin_o = bin_o | (sum_hot[v] ? W'(v) : '0);
    end
  end
endmodule

// File: rtl/sortnet_counter7.sv
module sortnet_counter7
  import sortnet_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  bits_i,
  output logic [CNT_W-1:0] count_o
);
  logic [GRP_A-1:0] therm4;
  logic [GRP_B-1:0] therm3;
  logic [GRP_A:0]   hot4;
  logic [GRP_B:0]   hot3;
  logic [CNT_W-1:0] cnt_d;

  sort4_net u_sort4 (.d_i(bits_i[GRP_A-1:0]),    .q_o(therm4));
  sort3_net u_sort3 (.d_i(bits_i[N_IN-1:GRP_A]), .q_o(therm3));

  therm_onehot #(.N(GRP_A)) u_hot4 (.t_i(therm4), .h_o(hot4));
  therm_onehot #(.N(GRP_B)) u_hot3 (.t_i(therm3), .h_o(hot3));

  onehot_sum #(.NA(GRP_A), .NB(GRP_B), .W(CNT_W)) u_sum (
    .ha_i (hot4),
    .hb_i (hot3),
    .bin_o(cnt_d)
  );

  if (REG_OUT) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
    end
    assign count_o = cnt_q;
  end else begin : g_comb
    assign count_o = cnt_d;
  end
endmodule

// File: rtl/sortnet_counter7_chk.sv
module sortnet_counter7_chk
  import sortnet_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IN-1:0]  bits_i,
  input logic [CNT_W-1:0] count_o,
  input logic [GRP_A-1:0] therm4,
  input logic [GRP_B-1:0] therm3,
  input logic [GRP_A:0]   hot4,
  input logic [GRP_B:0]   hot3
);
  a_r2_ones_kept_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(therm4) == $countones(bits_i[GRP_A-1:0]));
  a_r2_ones_kept_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(therm3) == $countones(bits_i[N_IN-1:GRP_A]));

  a_r4_therm_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm4 >> 1) & ~therm4) == '0);
  a_r4_therm_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((therm3 >> 1) & ~therm3) == '0);

  a_r5_onehot_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hot4) == 1 && hot4[$countones(bits_i[GRP_A-1:0])]);
  a_r5_onehot_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hot3) == 1 && hot3[$countones(bits_i[N_IN-1:GRP_A])]);

  if (REG_OUT) begin : g_reg
    a_r7_reg_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> count_o == CNT_W'($countones($past(bits_i))));
  end else begin : g_comb
    a_r6_comb_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o == CNT_W'($countones(bits_i)));
  end
endmodule

bind sortnet_counter7 sortnet_counter7_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .bits_i (bits_i),
  .count_o(count_o),
  .therm4 (therm4),
  .therm3 (therm3),
  .hot4   (hot4),
  .hot3   (hot3)
);

// File: tb/sortnet_counter7_tb.sv
module sortnet_counter7_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bits = '0;
  logic [2:0] cnt_reg, cnt_comb;
  int n_checks = 0;
  int n_fail   = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sortnet_counter7 #(.REG_OUT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bits_i(bits), .count_o(cnt_reg));
  sortnet_counter7 #(.REG_OUT(1'b0)) u_dut_comb (
    .clk_i(clk), .rst_ni(rst_n), .bits_i(bits), .count_o(cnt_comb));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s bits=%b actual=%0d expected=%0d", req, bits, act, exp);
    end
  endtask

  // drive at negedge, check comb at once, check register after next posedge
  task automatic apply(input logic [6:0] v, input string req);
    logic [2:0] e;
    @(negedge clk);
    bits = v;
    e = 3'($countones(v));
    #1;
    check({req, "/R6"}, cnt_comb, e);
    @(posedge clk);
    #1;
    check({req, "/R7"}, cnt_reg, e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    bits = 7'h7f;
    @(posedge clk); #1;
    check("R8 held in reset", cnt_reg, 3'd0);
    check("R6 comb during reset", cnt_comb, 3'd7);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7 first count", cnt_reg, 3'd7);
    // async clear mid-cycle
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", cnt_reg, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < 128; v++) apply(7'(v), "R1 exhaustive");
  endtask

  task automatic t_groups;
    apply(7'b000_1111, "R2 four-bit group full");
    apply(7'b111_0000, "R2 three-bit group full");
    apply(7'b101_0110, "R4 mixed order");
    for (int a = 0; a <= 4; a++)
      for (int b = 0; b <= 3; b++)
        apply({3'((1 << b) - 1), 4'((1 << a) - 1)}, "R5 group index");
  endtask

  task automatic t_single;
    for (int p = 0; p < 7; p++) apply(7'(1 << p), "R3 single one");
    for (int p = 0; p < 7; p++) apply(~7'(1 << p), "R3 single zero");
  endtask

  task automatic t_hold;
    apply(7'b110_0101, "R7 load");
    @(negedge clk);
    bits = 7'b000_0000;
    #1;
    check("R7 hold between edges", cnt_reg, 3'd4);
    check("R6 comb follows", cnt_comb, 3'd0);
    @(posedge clk); #1;
    check("R7 next edge", cnt_reg, 3'd0);
  endtask

  initial begin
    t_reset();
    t_exhaustive();
    t_groups();
    t_single();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule